// File: doc/BRIEF.md
# Embedded Interval and Watchdog Timer Facility

This block gives an embedded core three timers driven by one shared tick-enable. A down-counting interval timer raises a status bit after a programmed number of ticks. It can reload itself and run again. A fixed-period timer raises a status bit each time a chosen power-of-two number of ticks has elapsed. A watchdog escalates on every expiry of its chosen period. The first expiry arms it, the second raises an interrupt, and the third requests a reset of the kind that software selected.

Software talks to the block through three registers: a control word, a status word and the interval reload/count. One write port and one combinational read port serve all three, selected by a 2-bit code (0 control, 1 status, 2 interval). Status bits are cleared by writing ones. The block drives three level interrupt outputs and three single-cycle reset-request pulses. Acting on those reset pulses is left to logic outside the block.

The watchdog is a four-state machine whose state is the pair {arm, alert} held in status bits 31:30:
- WD_QUIET (00): an expiry moves it to WD_ARMED.
- WD_ARMED (10): an expiry moves it to WD_ALERT.
- WD_LATE (01): reached when software clears only the arm bit; an expiry moves it to WD_ALERT.
- WD_ALERT (11): an expiry keeps it in WD_ALERT and fires the reset action.

Software writes move the machine down by clearing either bit. Those clears are applied before the expiry in the same cycle.

Top module: `embtmr_top`

## Requirements
- R1: After reset every register reads 0, all interrupts are low and no reset pulse is driven. A control write keeps only bits 31:22; the other bits read back as 0.
- R2: Writing a one to status bit 31, 30, 29, 28, 27 or 26 clears that bit. Writing zeros leaves the status unchanged.
- R3: The fixed-period timer sets status bit 26 once every 2^(FIT_BASE+FIT_STEP*s) ticks, where s is control bits 25:24. The fit interrupt equals status bit 26 AND control bit 23.
- R4: A write of 0 or 1 to the interval register leaves the interval timer stopped, with count 0 and status bit 27 never set. A write of any value while control bit 26 is clear does the same.
- R5: When the interval register is written with N>1 and control bit 26 is set, the count reads N. It decreases by one per tick, and the tick that takes it from 1 sets status bit 27 and raises the pit interrupt.
- R6: At expiry the interval timer restarts from the reload value when control bit 22 is set. Otherwise it stops with count 0.
- R7: Writing a one to status bit 31 also drops the pit interrupt, while status bit 27 keeps its value.
- R8: The watchdog expires every 2^(WD_BASE+WD_STEP*w) ticks, where w is control bits 31:30.
- R9: On expiry the watchdog sets status bit 31 if it is clear. If bit 31 is already set and bit 30 is clear, it sets bit 30. The watchdog interrupt equals status bit 30 AND control bit 27.
- R10: An expiry with status bits 31 and 30 both set copies control bits 29:28 into status bits 29:28. It also drives a one-cycle pulse on the matching reset output: 1 core, 2 chip, 3 system, 0 none. At most one reset output is high at a time.
- R11: A control write with bit 26 clear stops a running interval timer. Its count reads 0 and it does not expire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One time-base tick per cycle when high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 status, 2 interval |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read source: 0 control, 1 status, 2 interval count |
| rd_data | output | 32 | Read data (combinational) |
| pit_irq | output | 1 | Interval timer interrupt (level) |
| fit_irq | output | 1 | Fixed-period timer interrupt (level) |
| wdt_irq | output | 1 | Watchdog interrupt (level) |
| rst_core | output | 1 | Core reset request pulse |
| rst_chip | output | 1 | Chip reset request pulse |
| rst_sys | output | 1 | System reset request pulse |

## Verification
The fixed-period timer is swept over all four period selects. Each select is sampled one tick before and at the expected expiry, which separates correct tap bits from neighbouring ones. The interval timer is run with every reload from 2 to 9, with auto-reload on and off, and with the degenerate reloads 0 and 1. These runs separate an off-by-one expiry, a missing reload and a wrongly started timer. The watchdog is walked through all three escalation stages for each of the four reset types and over every period select. A clear of only the arm bit shows that the machine re-enters the alert stage rather than restarting from the beginning.

// File: rtl/embtmr_pkg.sv
package embtmr_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_PIT  = 2'd2
    } reg_sel_e;

    // watchdog state encodes {arm, alert} status bits
    typedef enum logic [1:0] {
        WD_QUIET = 2'b00,
        WD_LATE  = 2'b01,
        WD_ARMED = 2'b10,
        WD_ALERT = 2'b11
    } wd_state_e;

    // control word fields
    localparam int C_WDP = 30;  // 2 bits
    localparam int C_WRT = 28;  // 2 bits
    localparam int C_WIE = 27;
    localparam int C_PIE = 26;
    localparam int C_FTP = 24;  // 2 bits
    localparam int C_FIE = 23;
    localparam int C_ARL = 22;
    // status word fields
    localparam int S_ARM = 31;
    localparam int S_ALR = 30;
    localparam int S_RST = 28;  // 2 bits
    localparam int S_PIT = 27;
    localparam int S_FIT = 26;

    localparam logic [31:0] CTRL_KEEP = 32'hFFC0_0000;
endpackage

// File: rtl/embtmr_timebase.sv
module embtmr_timebase #(
    parameter int FIT_BASE = 9,
    parameter int FIT_STEP = 4,
    parameter int WD_BASE  = 17,
    parameter int WD_STEP  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] fit_sel,
    input  logic [1:0] wd_sel,
    output logic       fit_evt,
    output logic       wd_evt
);
    localparam int FIT_TOP = FIT_BASE + 3 * FIT_STEP;
    localparam int WD_TOP  = WD_BASE + 3 * WD_STEP;
    localparam int TB_W    = (FIT_TOP > WD_TOP) ? FIT_TOP : WD_TOP;

    logic [TB_W-1:0] tb_q;
    logic [3:0]      fit_hit, wd_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     tb_q <= '0;
        else if (tick)  tb_q <= tb_q + 1'b1;
    end

    // a period ends when the low bits roll over to zero on this tick
    for (genvar g = 0; g < 4; g++) begin : g_tap
        localparam int FB = FIT_BASE + FIT_STEP * g;
        localparam int WB = WD_BASE + WD_STEP * g;
        assign fit_hit[g] = &tb_q[FB-1:0];
        assign wd_hit[g]  = &tb_q[WB-1:0];
    end

    assign fit_evt = tick & fit_hit[fit_sel];
    assign wd_evt  = tick & wd_hit[wd_sel];

    assert_tb_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (tb_q == $past(tb_q) + {{(TB_W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/embtmr_pit.sv
module embtmr_pit #(
    parameter int PIT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [PIT_W-1:0] load_val,
    input  logic             int_en,
    input  logic             auto_rl,
    input  logic             halt,
    output logic [PIT_W-1:0] count,
    output logic             expire
);
    localparam logic [PIT_W-1:0] ONE = {{(PIT_W-1){1'b0}}, 1'b1};

    logic [PIT_W-1:0] reload_q, cnt_q;
    logic             run_q;

    assign expire = run_q & tick & (cnt_q == ONE);
    assign count  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '0;
            run_q    <= 1'b0;
        end else if (load) begin
            reload_q <= load_val;
            if (load_val > ONE && int_en) begin
                run_q <= 1'b1;
                cnt_q <= load_val;
            end else begin
                run_q <= 1'b0;
                cnt_q <= '0;
            end
        end else if (halt) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (run_q && tick) begin
            if (cnt_q == ONE) begin
                if (auto_rl && int_en && reload_q > ONE) begin
                    cnt_q <= reload_q;
                end else begin
                    run_q <= 1'b0;
                    cnt_q <= '0;
                end
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assert_run_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q != '0));
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick && cnt_q > ONE && !load && !halt) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/embtmr_wdog.sv
module embtmr_wdog
    import embtmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt,
    input  logic       clr_arm,
    input  logic       clr_alr,
    input  logic [1:0] clr_rec,
    input  logic [1:0] rst_type,
    output logic       arm,
    output logic       alr,
    output logic [1:0] rec,
    output logic       rst_core,
    output logic       rst_chip,
    output logic       rst_sys
);
    wd_state_e state_q, base, state_d;
    logic      fire;
    logic [1:0] rec_q;
    logic       core_q, chip_q, sys_q;

    // software clears apply before a same-cycle expiry
    always_comb begin
        base    = wd_state_e'({state_q[1] & ~clr_arm, state_q[0] & ~clr_alr});
        state_d = base;
        fire    = 1'b0;
        if (evt) begin
            unique case (base)
                WD_QUIET: state_d = WD_ARMED;
                WD_LATE:  state_d = WD_ALERT;
                WD_ARMED: state_d = WD_ALERT;
                WD_ALERT: begin
                    state_d = WD_ALERT;
                    fire    = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q  <= 2'd0;
            core_q <= 1'b0;
            chip_q <= 1'b0;
            sys_q  <= 1'b0;
        end else begin
            rec_q  <= fire ? rst_type : (rec_q & ~clr_rec);
            core_q <= fire && (rst_type == 2'd1);
            chip_q <= fire && (rst_type == 2'd2);
            sys_q  <= fire && (rst_type == 2'd3);
        end
    end

    assign arm      = state_q[1];
    assign alr      = state_q[0];
    assign rec      = rec_q;
    assign rst_core = core_q;
    assign rst_chip = chip_q;
    assign rst_sys  = sys_q;

    assert_one_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_q, chip_q, sys_q}));
    assert_reset_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q | chip_q | sys_q) |=> !(core_q | chip_q | sys_q));
    assert_reset_from_alert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q | chip_q | sys_q) |-> (state_q == WD_ALERT));
endmodule

// File: rtl/embtmr_top.sv
module embtmr_top
    import embtmr_pkg::*;
#(
    parameter int PIT_W    = 32,
    parameter int FIT_BASE = 9,
    parameter int FIT_STEP = 4,
    parameter int WD_BASE  = 17,
    parameter int WD_STEP  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    output logic        pit_irq,
    output logic        fit_irq,
    output logic        wdt_irq,
    output logic        rst_core,
    output logic        rst_chip,
    output logic        rst_sys
);
    logic [31:0] tcr_q, w1c, tsr;
    logic        wr_ctrl, wr_stat, wr_pit;
    logic        fit_evt, wd_evt, pit_exp;
    logic        fit_st_q, pit_st_q, pit_irq_q;
    logic        arm, alr;
    logic [1:0]  rec;
    logic [PIT_W-1:0] pit_cnt;

    assign wr_ctrl = wr_en && (wr_sel == REG_CTRL);
    assign wr_stat = wr_en && (wr_sel == REG_STAT);
    assign wr_pit  = wr_en && (wr_sel == REG_PIT);
    assign w1c     = wr_stat ? wr_data : 32'd0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tcr_q <= 32'd0;
        else if (wr_ctrl) tcr_q <= wr_data & CTRL_KEEP;
    end

    embtmr_timebase #(
        .FIT_BASE(FIT_BASE), .FIT_STEP(FIT_STEP),
        .WD_BASE(WD_BASE),   .WD_STEP(WD_STEP)
    ) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick_en),
        .fit_sel(tcr_q[C_FTP+:2]), .wd_sel(tcr_q[C_WDP+:2]),
        .fit_evt(fit_evt), .wd_evt(wd_evt)
    );

    embtmr_pit #(.PIT_W(PIT_W)) u_pit (
        .clk(clk), .rst_n(rst_n), .tick(tick_en),
        .load(wr_pit), .load_val(wr_data[PIT_W-1:0]),
        .int_en(tcr_q[C_PIE]), .auto_rl(tcr_q[C_ARL]),
        .halt(wr_ctrl && !wr_data[C_PIE]),
        .count(pit_cnt), .expire(pit_exp)
    );

    embtmr_wdog u_wd (
        .clk(clk), .rst_n(rst_n), .evt(wd_evt),
        .clr_arm(w1c[S_ARM]), .clr_alr(w1c[S_ALR]), .clr_rec(w1c[S_RST+:2]),
        .rst_type(tcr_q[C_WRT+:2]),
        .arm(arm), .alr(alr), .rec(rec),
        .rst_core(rst_core), .rst_chip(rst_chip), .rst_sys(rst_sys)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fit_st_q  <= 1'b0;
            pit_st_q  <= 1'b0;
            pit_irq_q <= 1'b0;
        end else begin
            fit_st_q <= (fit_st_q & ~w1c[S_FIT]) | fit_evt;
            pit_st_q <= (pit_st_q & ~w1c[S_PIT]) | pit_exp;
            if (pit_exp && tcr_q[C_PIE])         pit_irq_q <= 1'b1;
            else if (w1c[S_PIT] || w1c[S_ARM])   pit_irq_q <= 1'b0;
        end
    end

    assign tsr = {arm, alr, rec, pit_st_q, fit_st_q, 26'd0};

    always_comb begin
        unique case (rd_sel)
            REG_CTRL: rd_data = tcr_q;
            REG_STAT: rd_data = tsr;
            REG_PIT:  rd_data = 32'(pit_cnt);
            default:  rd_data = 32'd0;
        endcase
    end

    assign pit_irq = pit_irq_q;
    assign fit_irq = fit_st_q & tcr_q[C_FIE];
    assign wdt_irq = alr & tcr_q[C_WIE];

    assert_pit_irq_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pit_irq_q |-> pit_st_q);
    assert_fit_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fit_evt |=> fit_st_q);
    assert_arm_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c[S_ARM] && !pit_exp) |=> !pit_irq_q);
endmodule

// File: tb/sim_embtmr_top.sv
`timescale 1ns/1ps
module sim_embtmr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        pit_irq, fit_irq, wdt_irq, rst_core, rst_chip, rst_sys;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    embtmr_top #(.PIT_W(8), .FIT_BASE(2), .FIT_STEP(1), .WD_BASE(4), .WD_STEP(1)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .pit_irq(pit_irq), .fit_irq(fit_irq), .wdt_irq(wdt_irq),
        .rst_core(rst_core), .rst_chip(rst_chip), .rst_sys(rst_sys)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_en = 1'b1;
            repeat (n) @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [2:0] pulses_exp(input int t);
        return (t == 0) ? 3'b000 : 3'(1 << (t - 1));
    endfunction

    localparam logic [1:0] CT = 2'd0, ST = 2'd1, PT = 2'd2;
    localparam logic [31:0] WD_SLOW = 32'hC000_0000;

    initial begin
        logic [31:0] v;
        do_reset();
        // R1 reset state
        rd(CT, v); chk("R1 ctrl reset", v, 0);
        rd(ST, v); chk("R1 stat reset", v, 0);
        rd(PT, v); chk("R1 pit reset", v, 0);
        chk("R1 irqs/pulses reset", {pit_irq, fit_irq, wdt_irq, rst_sys, rst_chip, rst_core}, 0);
        wr(CT, 32'hFFFF_FFFF);
        rd(CT, v); chk("R1 ctrl mask", v, 32'hFFC0_0000);

        // R3 fixed-period sweep
        for (int s = 0; s < 4; s++) begin
            int p;
            p = 1 << (2 + s);
            do_reset();
            wr(CT, WD_SLOW | (s << 24) | (1 << 23));
            ticks(p - 1);
            rd(ST, v); chk($sformatf("R3 fit early s=%0d", s), v[26], 0);
            ticks(1);
            rd(ST, v); chk($sformatf("R3 fit set s=%0d", s), v[26], 1);
            chk($sformatf("R3 fit irq s=%0d", s), fit_irq, 1);
            wr(ST, 0);
            rd(ST, v); chk("R2 zero write no effect", v[26], 1);
            wr(ST, 1 << 26);
            rd(ST, v); chk("R2 clear fit", v[26], 0);
            ticks(p);
            rd(ST, v); chk($sformatf("R3 fit again s=%0d", s), v[26], 1);
        end
        do_reset();
        wr(CT, WD_SLOW);
        ticks(4);
        rd(ST, v); chk("R3 fit status w/o enable", v[26], 1);
        chk("R3 fit irq disabled", fit_irq, 0);

        // R5 interval sweep without reload
        for (int n = 2; n < 10; n++) begin
            do_reset();
            wr(CT, WD_SLOW | (1 << 26));
            wr(PT, n);
            rd(PT, v); chk($sformatf("R5 load n=%0d", n), v, n);
            ticks(n - 1);
            rd(ST, v); chk($sformatf("R5 early n=%0d", n), v[27], 0);
            rd(PT, v); chk($sformatf("R5 count n=%0d", n), v, 1);
            ticks(1);
            rd(ST, v); chk($sformatf("R5 expire n=%0d", n), v[27], 1);
            chk($sformatf("R5 irq n=%0d", n), pit_irq, 1);
            ticks(3);
            rd(PT, v); chk($sformatf("R6 stopped n=%0d", n), v, 0);
        end
        // R7 arm-bit write drops the interval interrupt
        wr(ST, 32'h8000_0000);
        chk("R7 irq dropped", pit_irq, 0);
        rd(ST, v); chk("R7 status kept", v[27], 1);
        wr(ST, 1 << 27);
        rd(ST, v); chk("R2 clear pit status", v[27], 0);

        // R6 auto-reload
        do_reset();
        wr(CT, WD_SLOW | (1 << 26) | (1 << 22));
        wr(PT, 3);
        ticks(3);
        rd(ST, v); chk("R6 first expiry", v[27], 1);
        rd(PT, v); chk("R6 reloaded", v, 3);
        wr(ST, 1 << 27);
        ticks(3);
        rd(ST, v); chk("R6 second expiry", v[27], 1);
        ticks(2);
        rd(PT, v); chk("R6 counting", v, 1);
        // R11 control write with bit 26 clear stops it
        wr(CT, WD_SLOW | (1 << 22));
        wr(ST, 1 << 27);
        rd(PT, v); chk("R11 halted count", v, 0);
        ticks(5);
        rd(ST, v); chk("R11 no expiry", v[27], 0);

        // R4 degenerate reloads and disabled timer
        do_reset();
        wr(CT, WD_SLOW | (1 << 26));
        for (int r = 0; r < 2; r++) begin
            wr(PT, r);
            ticks(12);
            rd(ST, v); chk($sformatf("R4 reload %0d no status", r), v[27], 0);
            rd(PT, v); chk($sformatf("R4 reload %0d count", r), v, 0);
        end
        wr(CT, WD_SLOW);
        wr(PT, 4);
        ticks(8);
        rd(ST, v); chk("R4 disabled no status", v[27], 0);
        rd(PT, v); chk("R4 disabled count", v, 0);

        // R9/R10 escalation for each reset type (period 16 ticks)
        for (int t = 0; t < 4; t++) begin
            do_reset();
            wr(CT, (t << 28) | (1 << 27));
            ticks(15);
            rd(ST, v); chk($sformatf("R9 not armed t=%0d", t), v[31:30], 2'b00);
            ticks(1);
            rd(ST, v); chk($sformatf("R9 armed t=%0d", t), v[31:30], 2'b10);
            chk($sformatf("R9 no irq yet t=%0d", t), wdt_irq, 0);
            ticks(16);
            rd(ST, v); chk($sformatf("R9 alert t=%0d", t), v[31:30], 2'b11);
            chk($sformatf("R9 irq t=%0d", t), wdt_irq, 1);
            chk($sformatf("R10 no pulse before t=%0d", t), {rst_sys, rst_chip, rst_core}, 0);
            ticks(16);
            rd(ST, v); chk($sformatf("R10 record t=%0d", t), v[29:28], t);
            chk($sformatf("R10 pulse t=%0d", t), {rst_sys, rst_chip, rst_core}, pulses_exp(t));
            @(negedge clk);
            chk($sformatf("R10 pulse ends t=%0d", t), {rst_sys, rst_chip, rst_core}, 0);
        end

        // R8 period select sweep
        for (int s = 1; s < 4; s++) begin
            int p;
            p = 1 << (4 + s);
            do_reset();
            wr(CT, s << 30);
            ticks(p - 1);
            rd(ST, v); chk($sformatf("R8 early w=%0d", s), v[31], 0);
            ticks(1);
            rd(ST, v); chk($sformatf("R8 expiry w=%0d", s), v[31], 1);
        end

        // R9 irq disabled, then a partial clear re-enters alert
        do_reset();
        wr(CT, 0);
        ticks(32);
        rd(ST, v); chk("R9 alert w/o enable", v[31:30], 2'b11);
        chk("R9 irq disabled", wdt_irq, 0);
        wr(ST, 32'h8000_0000);
        rd(ST, v); chk("R2 clear arm only", v[31:30], 2'b01);
        wr(CT, 2 << 28);
        ticks(16);
        rd(ST, v); chk("R9 late to alert", v[31:30], 2'b11);
        chk("R10 no pulse on re-alert", {rst_sys, rst_chip, rst_core}, 0);
        ticks(16);
        rd(ST, v); chk("R10 chip record", v[29:28], 2);
        chk("R10 chip pulse", {rst_sys, rst_chip, rst_core}, 3'b010);
        wr(ST, 32'h3000_0000);
        rd(ST, v); chk("R2 clear record", v[29:28], 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule